// File: doc/BRIEF.md
# Pipelined Cascadable Bus Parity Checker

This block checks parity on a 12-bit data bus where the parity bit for a word shows up one clock after the word itself. The block registers the XOR of each data word so that it lines up with the late parity bit. One clock after that parity bit, it produces a registered, active-low error flag. The flag is modelled as open drain: a 0 means the pin is pulled low and a 1 means it is released and reads high.

A single parity port has two uses. In standalone use (`par_oe_n` high), the port is an input that selects the parity sense: 0 selects even and 1 selects odd. Two checkers can also be chained to cover a 24-bit word. The head checker has `par_oe_n` low and drives a partial sum onto the port. That sum is its registered data parity XOR its own delayed-parity input, so on the head, `par_dly` carries the even/odd selection for the pair. The tail checker has `par_oe_n` high and folds the port value into its own check. The tail's `par_dly` carries the real parity bit.

Data bit 11 also acts as an active-low load enable for the error register. The enable is sampled on the same edge that would load a new error result.

Top module: `bus_parity_checker`

## Requirements
- R1: At each rising clock edge the XOR of all 12 `din` bits is registered. On a cascade head, `pio_out` in the following cycle equals that registered parity XOR the current `par_dly`.
- R2: With `par_oe_n` high and `din[11]` low at an edge, `err_n` after that edge is 0 when (registered data parity XOR `par_dly` XOR `pio_in`) is 1, and 1 otherwise. The flag therefore appears one clock after the parity bit and two clocks after the data.
- R3: In standalone use, `pio_in`=0 checks even parity (the data and parity bit together hold an even number of ones) and `pio_in`=1 checks odd parity.
- R4: When `din[11]` is high at an edge, `err_n` keeps its previous value.
- R5: With `par_oe_n` low, `pio_oe` is 1 and the block drives the partial sum of R1 on `pio_out`. With `par_oe_n` high, `pio_oe` is 0.
- R6: On a cascade head (`par_oe_n` low), the error register loads the released value 1 whenever it is enabled.
- R7: In a chained pair whose tail takes the head's `pio_out` on its `pio_in`, the tail's `err_n` flags a mismatch over the full 24-bit word. The expected total is even when the head's `par_dly` is 0 and odd when it is 1.
- R8: A synchronous active-high `rst` releases `err_n` (1) and clears the registered data parity. A head held in reset therefore outputs `pio_out` equal to `par_dly`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 12 | Data word; bit 11 is also the active-low error-load enable |
| par_dly | input | 1 | Parity bit, valid one cycle after its word (selection bit on a head) |
| par_oe_n | input | 1 | Low: cascade head driving the port; high: standalone or tail |
| pio_in | input | 1 | Parity port input: sense select or partial sum |
| pio_out | output | 1 | Parity port output value (partial sum) |
| pio_oe | output | 1 | Parity port drive enable |
| err_n | output | 1 | Error flag, 0 = driven low, 1 = released |

## Verification
Several properties are checked on every cycle:
- the error flag follows the three-way XOR of the previous cycle whenever a tail or standalone checker is enabled;
- the flag holds while bit 11 is high;
- a head never flags;
- a head always drives its partial sum;
- reset releases the flag.

Other behaviour can only be shown by the bench scenarios. These are the correct alignment of a word with its late parity bit across a real two-cycle sequence, and the 24-bit result of an actual head/tail pair under both even and odd selection. The bench also shows that a latched error survives a disabled edge and is cleared by reset.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic {
        ROLE_CHECK = 1'b0,
        ROLE_HEAD  = 1'b1
    } role_e;

    typedef struct packed {
        logic drive;
        logic value;
    } port_drv_t;

    function automatic logic mismatch(input logic word_par,
                                      input logic late_par,
                                      input logic port_term);
        return word_par ^ late_par ^ port_term;
    endfunction

endpackage

// File: rtl/bpc_parity_stage.sv
module bpc_parity_stage #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] word,
    output logic             par_q
);
    always_ff @(posedge clk) begin
        if (rst) par_q <= 1'b0;
        else     par_q <= ^word;
    end
endmodule

// File: rtl/bpc_port_ctrl.sv
module bpc_port_ctrl
    import bpc_pkg::*;
(
    input  logic      par_oe_n,
    input  logic      par_q,
    input  logic      par_dly,
    input  logic      pio_in,
    output role_e     role,
    output port_drv_t drv,
    output logic      fault
);
    always_comb begin
        role      = par_oe_n ? ROLE_CHECK : ROLE_HEAD;
        drv.drive = (role == ROLE_HEAD);
        drv.value = par_q ^ par_dly;
        if (role == ROLE_HEAD) fault = 1'b0;
        else                   fault = mismatch(par_q, par_dly, pio_in);
    end
endmodule

// File: rtl/bpc_err_reg.sv
module bpc_err_reg (
    input  logic clk,
    input  logic rst,
    input  logic ld_n,
    input  logic fault,
    output logic err_n
);
    always_ff @(posedge clk) begin
        if (rst)        err_n <= 1'b1;
        else if (!ld_n) err_n <= ~fault;
    end

    // R4: a disabled edge leaves the flag unchanged
    a_r4_hold_flag: assert property (@(posedge clk) disable iff (rst)
        ld_n |=> $stable(err_n));
endmodule

// File: rtl/bus_parity_checker.sv
module bus_parity_checker
    import bpc_pkg::*;
#(
    parameter int WIDTH   = 12,
    parameter int ENA_BIT = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    input  logic             par_dly,
    input  logic             par_oe_n,
    input  logic             pio_in,
    output logic             pio_out,
    output logic             pio_oe,
    output logic             err_n
);
    localparam int EB = (ENA_BIT < WIDTH) ? ENA_BIT : WIDTH - 1;

    logic      par_q;
    logic      fault;
    role_e     role;
    port_drv_t drv;

    bpc_parity_stage #(.WIDTH(WIDTH)) u_stage (
        .clk   (clk),
        .rst   (rst),
        .word  (din),
        .par_q (par_q)
    );

    bpc_port_ctrl u_port (
        .par_oe_n (par_oe_n),
        .par_q    (par_q),
        .par_dly  (par_dly),
        .pio_in   (pio_in),
        .role     (role),
        .drv      (drv),
        .fault    (fault)
    );

    bpc_err_reg u_err (
        .clk   (clk),
        .rst   (rst),
        .ld_n  (din[EB]),
        .fault (fault),
        .err_n (err_n)
    );

    assign pio_out = drv.value;
    assign pio_oe  = drv.drive;

    // R2: enabled checker loads the inverted three-way XOR of the prior cycle
    a_r2_flag_value: assert property (@(posedge clk) disable iff (rst)
        (par_oe_n && !din[EB]) |=> (err_n == !$past(par_q ^ par_dly ^ pio_in)));

    // R6: a head never pulls the flag low on an enabled edge
    a_r6_head_released: assert property (@(posedge clk) disable iff (rst)
        (!par_oe_n && !din[EB]) |=> err_n);

    // R5: a head drives its partial sum
    a_r5_head_drives: assert property (@(posedge clk) disable iff (rst)
        !par_oe_n |-> (pio_oe && (pio_out == (par_q ^ par_dly))));

    // R8: reset releases the flag and clears the stage
    a_r8_reset_state: assert property (@(posedge clk)
        rst |=> (err_n && !par_q));
endmodule

// File: tb/sim_bus_parity_checker.sv
module sim_bus_parity_checker;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 8;

    // {cascade, sel, pbit, head word, tail word}
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 12'h000, 12'h000},
        {1'b0, 1'b0, 1'b0, 12'h000, 12'h001},
        {1'b0, 1'b1, 1'b0, 12'h000, 12'h001},
        {1'b0, 1'b1, 1'b0, 12'h000, 12'hFFF},
        {1'b1, 1'b0, 1'b1, 12'h100, 12'h003},
        {1'b1, 1'b0, 1'b0, 12'h001, 12'hA5A},
        {1'b1, 1'b1, 1'b0, 12'h000, 12'h800},
        {1'b1, 1'b1, 1'b0, 12'h000, 12'h000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [11:0] din0 = '0, din1 = '0;
    logic pd0 = 1'b0, pd1 = 1'b0;
    logic oe0_n = 1'b1, oe1_n = 1'b1;
    logic sel = 1'b0, casc = 1'b0;
    logic pio_in0, pio_out0, pio_oe0, err0_n;
    logic pio_out1, pio_oe1, err1_n;
    int checks = 0, errors = 0, cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pio_in0 = casc ? pio_out1 : sel;

    bus_parity_checker u0 (
        .clk(clk), .rst(rst), .din(din0), .par_dly(pd0), .par_oe_n(oe0_n),
        .pio_in(pio_in0), .pio_out(pio_out0), .pio_oe(pio_oe0), .err_n(err0_n));

    bus_parity_checker u1 (
        .clk(clk), .rst(rst), .din(din1), .par_dly(pd1), .par_oe_n(oe1_n),
        .pio_in(sel), .pio_out(pio_out1), .pio_oe(pio_oe1), .err_n(err1_n));

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Starts at a negedge; ends at the negedge where err_n is sampled.
    task automatic run_word(input logic c, input logic s, input logic p,
                            input logic [11:0] hw, input logic [11:0] tw,
                            input logic hold, input logic exp_err_n);
        casc  = c;
        oe1_n = !c;
        sel   = s;
        din0  = tw;
        din1  = hw;
        @(posedge clk);
        @(negedge clk);
        pd0  = p;
        pd1  = c ? s : p;
        din0 = hold ? 12'h800 : 12'h000;
        din1 = 12'h000;
        #1;
        if (c) begin
            check("R1 head partial sum", pio_out1, (^hw) ^ s);
            check("R5 head drive enable", pio_oe1, 1'b1);
        end
        @(posedge clk);
        @(negedge clk);
        if (c) begin
            check("R7 cascaded 24-bit flag", err0_n, exp_err_n);
            check("R6 head flag released", err1_n, 1'b1);
        end else begin
            check(hold ? "R4 flag held" : "R2/R3 standalone flag", err0_n, exp_err_n);
        end
    endtask

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
        finish_run();
    end

    initial begin
        oe1_n = 1'b0;
        pd1   = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 reset state
        check("R8 err_n released u0", err0_n, 1'b1);
        check("R8 err_n released u1", err1_n, 1'b1);
        check("R8 head pio_out equals par_dly", pio_out1, 1'b1);
        check("R5 standalone not driving", pio_oe0, 1'b0);
        rst = 1'b0;
        oe1_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic c, s, p, e;
            logic [11:0] hw, tw;
            {c, s, p, hw, tw} = VEC[i];
            e = c ? (^tw) ^ (^hw) ^ p ^ s : (^tw) ^ p ^ s;
            run_word(c, s, p, hw, tw, 1'b0, !e);
        end

        // R4: latch an error, then a disabled edge must keep it
        run_word(1'b0, 1'b0, 1'b1, 12'h000, 12'h000, 1'b0, 1'b0);
        run_word(1'b0, 1'b0, 1'b0, 12'h000, 12'h000, 1'b1, 1'b0);
        run_word(1'b0, 1'b0, 1'b0, 12'h000, 12'h000, 1'b0, 1'b1);

        // R8: reset clears a latched error
        run_word(1'b0, 1'b1, 1'b0, 12'h000, 12'h000, 1'b0, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8 reset releases latched error", err0_n, 1'b1);
        rst = 1'b0;

        finish_run();
    end
endmodule